// File: doc/BRIEF.md
# Modulo Sample Unwrapper

This block rebuilds a wide, unfolded sample stream from the output of a folding converter. Each incoming sample is the true value reduced into the half-open range [-λ, λ). The block recovers the integer number of 2λ periods that were removed from each sample and adds them back. The folded range is the full signed range of the input word, so λ is a power of two and the 2λ scaling is a plain bit shift.

By default the period count comes from the difference between consecutive folded samples. The difference is wrapped back into [-λ, λ), and whenever the wrap changes it, the count moves by one. This only works when the input is oversampled enough that neighbouring true samples differ by less than λ. For each sample the caller can instead choose to trust a one-bit fold marker from the converter. In that case the marker alone decides whether the count moves, and the sign of the raw difference gives the direction.

Samples enter and leave on valid/ready handshakes through a two-stage pipeline. The running count saturates at the limits of its signed width. A sticky error flag records any saturation.

Top module: `modulo_unwrap`

## Requirements
- R1: The input sample is a DATA_W-bit two's complement value with λ = 2^(DATA_W-1). The output word is signed, OUT_W = DATA_W+K_W+1 bits wide, and equals sample + k·2^DATA_W. Here k is the K_W-bit signed period count, which is also presented on its own port.
- R2: The first sample accepted after reset leaves k at zero, whatever its value.
- R3: When mode_i=0, let d be the integer difference between the accepted sample and the previously accepted sample. If d ≥ λ then k decreases by one. If d < -λ then k increases by one. Otherwise k is unchanged. fold_i is ignored in this mode.
- R4: When mode_i=1 and fold_i=0, k is unchanged no matter how large d is. When mode_i=1 and fold_i=1, k increases by one if d < 0 and decreases by one otherwise.
- R5: While out_valid_o is high and out_ready_i is low, out_valid_o, out_data_o and k_o hold their values. in_ready_o is high whenever the output stage is empty or is being drained.
- R6: With out_ready_i held high, a sample accepted in cycle c is presented with out_valid_o high in cycle c+2, and out_valid_o is low in cycle c+1.
- R7: k never leaves [-2^(K_W-1), 2^(K_W-1)-1]. A step that would cross a limit leaves k at that limit and raises err_o. err_o appears together with the output of that sample and stays high until reset.
- R8: After reset, out_valid_o and err_o are low and in_ready_o is high.
- R9: Each accepted sample produces exactly one output, in acceptance order, under any pattern of stalls on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block can take a sample |
| in_sample_i | input | DATA_W | Folded sample, two's complement |
| mode_i | input | 1 | 0: infer folds from difference, 1: use fold_i |
| fold_i | input | 1 | Per-sample fold marker |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream takes the output |
| out_data_o | output | OUT_W | Unfolded sample, signed |
| k_o | output | K_W | Period count for this output, signed |
| err_o | output | 1 | Sticky saturation flag |

## Verification
The bench drives a random walk of true values through the bench's own fold model. It sends the walk in both modes with random stalls on both sides, so a design that misplaces the wrap threshold by one count drifts by 2λ at the first difference of exactly ±λ. Directed cases give a large jump with no fold marker and a small jump with one, which catches a design that mixes the two inference paths. A lone first sample catches a stale previous value, because a design that fails to seed it would shift the first output by 2λ. Long ramps push k into both limits, which exposes wrap-around instead of clamping and an error flag that fails to stick. A held output under backpressure exposes data that changes while stalled, and lost or duplicated words.

// File: rtl/modulo_unwrap_pkg.sv
package modulo_unwrap_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/mu_step.sv
module mu_step
  import modulo_unwrap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] prev_i,
  input  logic              first_i,
  input  logic              mode_i,
  input  logic              fold_i,
  output step_e             step_o
);
  localparam logic signed [DATA_W:0] LAM_P = {2'b01, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W:0] LAM_N = {2'b11, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0] diff;

  always_comb begin
    diff   = $signed({cur_i[DATA_W-1], cur_i}) - $signed({prev_i[DATA_W-1], prev_i});
    step_o = STEP_NONE;
    if (!first_i) begin
      if (mode_i) begin
        // marker decides if, sign of raw difference decides direction
        if (fold_i) step_o = diff[DATA_W] ? STEP_UP : STEP_DN;
      end else begin
        if (diff >= LAM_P)     step_o = STEP_DN;
        else if (diff < LAM_N) step_o = STEP_UP;
      end
    end
  end
endmodule

// File: rtl/mu_acc.sv
module mu_acc
  import modulo_unwrap_pkg::*;
#(
  parameter int K_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           upd_i,
  input  step_e          step_i,
  output logic [K_W-1:0] k_o,
  output logic           err_o
);
  localparam logic signed [K_W-1:0] K_MAX = {1'b0, {(K_W-1){1'b1}}};
  localparam logic signed [K_W-1:0] K_MIN = {1'b1, {(K_W-1){1'b0}}};
  localparam logic signed [K_W-1:0] K_ONE = {{(K_W-1){1'b0}}, 1'b1};

  logic signed [K_W-1:0] k_q, k_nxt;
  logic                  err_q, hit;

  always_comb begin
    hit   = (step_i == STEP_UP && k_q == K_MAX) || (step_i == STEP_DN && k_q == K_MIN);
    k_nxt = k_q;
    if (!hit) begin
      if (step_i == STEP_UP)      k_nxt = k_q + K_ONE;
      else if (step_i == STEP_DN) k_nxt = k_q - K_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q   <= '0;
      err_q <= 1'b0;
    end else if (upd_i) begin
      k_q   <= k_nxt;
      err_q <= err_q | hit;
    end
  end

  assign k_o   = k_q;
  assign err_o = err_q;

  // R3: at most one period per update
  a_r3_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (k_q == $past(k_q)) || (k_q == $past(k_q) + K_ONE) || (k_q == $past(k_q) - K_ONE));
  a_r7_clamp_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && step_i == STEP_UP && k_q == K_MAX |=> k_q == K_MAX && err_q);
  a_r7_clamp_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && step_i == STEP_DN && k_q == K_MIN |=> k_q == K_MIN && err_q);
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/modulo_unwrap.sv
module modulo_unwrap
  import modulo_unwrap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int K_W    = 6,
  localparam int OUT_W = DATA_W + K_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_sample_i,
  input  logic              mode_i,
  input  logic              fold_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OUT_W-1:0]  out_data_o,
  output logic [K_W-1:0]    k_o,
  output logic              err_o
);
  logic              advance, accept;
  logic [DATA_W-1:0] prev_q;
  logic              have_prev_q;
  step_e             step_c, s1_step_q;
  logic              s1_valid_q;
  logic [DATA_W-1:0] s1_y_q;
  logic              out_valid_q;
  logic [DATA_W-1:0] out_y_q;
  logic [K_W-1:0]    k_q;

  // single stall for both stages
  assign advance    = !out_valid_q || out_ready_i;
  assign in_ready_o = advance;
  assign accept     = in_valid_i && advance;

  mu_step #(.DATA_W(DATA_W)) u_step (
    .cur_i   (in_sample_i),
    .prev_i  (prev_q),
    .first_i (!have_prev_q),
    .mode_i  (mode_i),
    .fold_i  (fold_i),
    .step_o  (step_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (accept) begin
      prev_q      <= in_sample_i;
      have_prev_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q  <= 1'b0;
      s1_y_q      <= '0;
      s1_step_q   <= STEP_NONE;
      out_valid_q <= 1'b0;
      out_y_q     <= '0;
    end else if (advance) begin
      s1_valid_q  <= in_valid_i;
      out_valid_q <= s1_valid_q;
      if (in_valid_i) begin
        s1_y_q    <= in_sample_i;
        s1_step_q <= step_c;
      end
      if (s1_valid_q) out_y_q <= s1_y_q;
    end
  end

  mu_acc #(.K_W(K_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (advance && s1_valid_q),
    .step_i (s1_step_q),
    .k_o    (k_q),
    .err_o  (err_o)
  );

  assign out_valid_o = out_valid_q;
  assign k_o         = k_q;
  assign out_data_o  = {k_q[K_W-1], k_q, {DATA_W{1'b0}}}
                     + {{(K_W+1){out_y_q[DATA_W-1]}}, out_y_q};

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(k_o));
  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q && in_ready_o |=> out_valid_o);
  a_r2_first_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !have_prev_q |=> s1_step_q == STEP_NONE);
endmodule

// File: tb/modulo_unwrap_tb.sv
module modulo_unwrap_tb;
  localparam int DW = 8;
  localparam int KW = 6;
  localparam int OW = DW + KW + 1;
  localparam int LAM = 1 << (DW - 1);
  localparam int KMAX = (1 << (KW - 1)) - 1;
  localparam int KMIN = -(1 << (KW - 1));

  logic clk = 0, rst_ni = 0;
  logic in_valid = 0, in_ready, mode = 0, fold = 0;
  logic [DW-1:0] in_sample = '0;
  logic out_valid, out_ready = 0, err;
  logic [OW-1:0] out_data;
  logic [KW-1:0] k_out;

  always #10 clk = ~clk;

  modulo_unwrap #(.DATA_W(DW), .K_W(KW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_sample_i(in_sample), .mode_i(mode), .fold_i(fold), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .k_o(k_out), .err_o(err));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int m_prev, m_k;
  bit m_have, m_err, last_acc;
  int q_data[$], q_k[$];
  bit q_err[$];
  string q_tag[$];

  function automatic int fold_of(int x);
    return (((x + LAM) % (2*LAM)) + 2*LAM) % (2*LAM) - LAM;
  endfunction
  function automatic int per_of(int x);
    return (x + LAM - (fold_of(x) + LAM)) / (2*LAM);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_accept(int y, bit md, bit fb, string tag);
    int d, st;
    d = y - m_prev;
    st = 0;
    if (m_have) begin
      if (md) begin
        if (fb) st = (d < 0) ? 1 : -1;
      end else if (d >= LAM) st = -1;
      else if (d < -LAM) st = 1;
    end
    if (m_k + st > KMAX || m_k + st < KMIN) m_err = 1;
    else m_k = m_k + st;
    m_have = 1;
    m_prev = y;
    q_data.push_back(y + m_k * 2 * LAM);
    q_k.push_back(m_k);
    q_err.push_back(m_err);
    q_tag.push_back(tag);
  endtask

  // evaluate the cycle after inputs settle, then move to the next negedge
  task automatic tick(string tag);
    #1;
    last_acc = in_valid && in_ready;
    if (last_acc) model_accept($signed(in_sample), mode, fold, tag);
    if (out_valid && out_ready) begin
      if (q_data.size() == 0) chk(0, "R9 extra output", 1, 0);
      else begin
        chk($signed(out_data) == q_data[0], {q_tag[0], " data"}, $signed(out_data), q_data[0]);
        chk($signed(k_out) == q_k[0], {q_tag[0], " k"}, $signed(k_out), q_k[0]);
        chk(err == q_err[0], {q_tag[0], " err"}, err, q_err[0]);
        void'(q_data.pop_front()); void'(q_k.pop_front());
        void'(q_err.pop_front()); void'(q_tag.pop_front());
      end
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 0; in_valid = 0; out_ready = 0; mode = 0; fold = 0;
    m_have = 0; m_k = 0; m_err = 0; m_prev = 0;
    q_data.delete(); q_k.delete(); q_err.delete(); q_tag.delete();
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic send(int y, bit md, bit fb, string tag);
    in_valid = 1; in_sample = y[DW-1:0]; mode = md; fold = fb;
    for (int i = 0; i < 50; i++) begin
      tick(tag);
      if (last_acc) break;
    end
    in_valid = 0;
  endtask

  task automatic drain(string tag);
    in_valid = 0; out_ready = 1;
    for (int i = 0; i < 20 && q_data.size() > 0; i++) tick(tag);
    chk(q_data.size() == 0, {tag, " R9 drained"}, q_data.size(), 0);
  endtask

  // random walk of true values, folded by the bench model
  task automatic stream(int n, bit md, int maxstep, int dir, int pv, int pr, string tag);
    int x, xn, sent;
    x = $urandom_range(0, 2*LAM-1) - LAM;
    xn = x; sent = 0;
    for (int c = 0; c < 20*n && sent < n; c++) begin
      out_ready = ($urandom_range(0, 99) < pr);
      if ($urandom_range(0, 99) < pv) begin
        in_valid = 1; in_sample = fold_of(xn); mode = md;
        fold = (sent > 0) && (per_of(xn) != per_of(x));
      end else in_valid = 0;
      tick(tag);
      if (last_acc) begin
        sent++;
        x = xn;
        if (dir == 0) xn = x + $urandom_range(0, 2*maxstep) - maxstep;
        else xn = x + dir * $urandom_range(maxstep/2, maxstep);
      end
    end
    drain(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int d1, d2;
    void'($urandom(1234));
    do_reset();
    #1;
    chk(out_valid == 0, "R8 out_valid", out_valid, 0);
    chk(err == 0, "R8 err", err, 0);
    chk(in_ready == 1, "R8 in_ready", in_ready, 1);
    @(negedge clk);

    // R6 latency and R2 first sample
    out_ready = 1; in_valid = 1; in_sample = 8'd156; mode = 0; fold = 0;  // -100
    #1; chk(in_ready == 1, "R6 accept", in_ready, 1);
    @(negedge clk); in_valid = 0; #1;
    chk(out_valid == 0, "R6 c+1 empty", out_valid, 1'b0);
    @(negedge clk); #1;
    chk(out_valid == 1, "R6 c+2 valid", out_valid, 1);
    chk($signed(out_data) == -100, "R2 first data", $signed(out_data), -100);
    chk($signed(k_out) == 0, "R2 first k", $signed(k_out), 0);

    // R2 first sample with a value far from reset prev
    do_reset(); out_ready = 1;
    send(127, 0, 0, "R2"); send(-128, 0, 0, "R3"); send(127, 0, 0, "R3");
    send(0, 0, 1, "R3 fold ignored"); send(-128, 0, 0, "R3 d=-128 no step");
    drain("R3");

    // R4 marker mode corners
    do_reset(); out_ready = 1;
    send(100, 1, 0, "R4"); send(-100, 1, 0, "R4 big jump no marker");
    send(-50, 1, 1, "R4 small jump marker up"); send(-50, 1, 1, "R4 zero jump marker");
    send(-120, 1, 1, "R4 neg jump marker");
    drain("R4");

    // R5 hold under backpressure
    do_reset(); out_ready = 0;
    send(40, 0, 0, "R5"); send(-30, 0, 0, "R5");
    @(negedge clk); #1;
    d1 = $signed(out_data);
    repeat (3) @(negedge clk);
    #1; d2 = $signed(out_data);
    chk(out_valid == 1, "R5 held valid", out_valid, 1);
    chk(d1 == d2, "R5 held data", d2, d1);
    @(negedge clk);
    drain("R5");

    // R3, R9 random walks with stalls
    do_reset(); stream(300, 0, 120, 0, 70, 60, "R3 R9 diff mode");
    do_reset(); stream(300, 1, 127, 0, 80, 50, "R4 R9 marker mode");
    do_reset(); stream(200, 0, 127, 0, 100, 100, "R1 full rate");

    // R7 saturation both ways
    do_reset(); stream(100, 0, 120, 1, 90, 80, "R7 up");
    #1; chk(err == 1, "R7 sticky err", err, 1);
    chk($signed(k_out) == KMAX, "R7 k max", $signed(k_out), KMAX);
    @(negedge clk);
    do_reset(); stream(100, 1, 120, -1, 90, 80, "R7 down");
    #1; chk(err == 1, "R7 sticky err low", err, 1);
    chk($signed(k_out) == KMIN, "R7 k min", $signed(k_out), KMIN);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule